// File: doc/BRIEF.md
# Time-Division Output Multiplexer

This block turns the head words of eighteen per-channel FIFOs into a fixed, repeating stream of 32-bit words for an optical serializer that runs at 25 MHz. Each round has 21 steps. Eighteen of them belong to the channels in a fixed order, one carries a synchronization spacer word, and two are link-idle characters. The receiver learns which channel sent a word only from the step in which the word arrives. It therefore never needs a source tag, and it can find its place in the round from the spacer.

For a channel step, the block takes the FIFO head word and pops it. If the FIFO is empty, the block sends an all-zero empty-channel marker instead. Before a data word is forwarded, two of its upper bits are replaced. One records a parity fault that was found when the word arrived. The other makes the whole outgoing word odd parity.

The stream starts only after the link is up and an enable (the first trigger) has been seen. A round in which no FIFO holds data is not sent at all. Losing the link stops the stream and rewinds the step counter, and the block then waits for a new enable.

Top module: `tdm_mux`

## Requirements
- R1: While reset is low, and on the first cycle after it, tx_ctrl is 00, tx_data is zero and no fifo_pop bit is set.
- R2: Once running, the step counter visits the spacer step (18), then the two idle steps (19, 20), then channels 0 to 17 in ascending order, and repeats. Each step lasts one clock, and its output word appears on the cycle after the step.
- R3: The spacer step outputs tx_data = 0xD0000000 with tx_ctrl = 01.
- R4: In channel step k, when FIFO k is not empty, fifo_pop[k] is high in that same cycle, and the forwarded word appears on the next cycle with tx_ctrl = 01.
- R5: In channel step k, when FIFO k is empty, no pop is issued and the next output is tx_data = 0x00000000 with tx_ctrl = 01.
- R6: A forwarded word keeps bits 31:28 and 25:0 of the FIFO word. Bit 27 equals the FIFO's parity-error input. Bit 26 is chosen so that all 32 bits have odd parity.
- R7: The two idle steps output tx_ctrl = 00 (serializer idle, data ignored) with tx_data zero. The block never drives control codes 10 (extend) or 11 (transmit error).
- R8: Until link_up and enable have both been high in the same cycle, the block stays inactive. While inactive, tx_ctrl stays 00 and no pop is issued.
- R9: Whether a round is sent is decided at its spacer step. If every FIFO is empty in that cycle, all 21 steps of the round output tx_ctrl = 00 with zero data and issue no pops.
- R10: When link_up goes low, pops stop in that same cycle. The next output is idle, the counter returns to step 18, and the block stays inactive until link_up and enable are high together again.
- R11: At most one fifo_pop bit is high in any cycle, and never the bit of an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Serial link is synchronized |
| enable | input | 1 | Arms the stream (first trigger seen) |
| fifo_empty | input | 18 | Per-channel FIFO empty flags |
| fifo_data | input | 576 | Per-channel FIFO head words, channel k at bits 32k+31:32k |
| fifo_perr | input | 18 | Per-channel parity-error flag of the head word |
| fifo_pop | output | 18 | Per-channel pop strobe |
| tx_data | output | 32 | Word to the serializer |
| tx_ctrl | output | 2 | Serializer control code: 00 idle, 01 send data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the round-suppression decision and the arrival of new data. The bench pushes words at random into FIFOs on every cycle, including the spacer step, so a word that lands exactly at the decision point must make the round live. A word that lands one step later must wait for the next round. The second pair is a link drop and a pending pop. The bench removes link_up in the middle of a round, while a channel step holds data. Every cycle it compares the pop vector and the next word against a per-cycle model of the round built from the requirements.

// File: rtl/tdm_pkg.sv
// Shared constants and types for the time-division output multiplexer.
// Assumes the serializer control codes 00 = idle, 01 = send data.
package tdm_pkg;
    localparam logic [1:0] CTL_IDLE = 2'b00;
    localparam logic [1:0] CTL_DATA = 2'b01;

    // Kind of word owned by a step of the round
    typedef enum logic [1:0] {
        SLOT_CHAN     = 2'd0,
        SLOT_SPACER   = 2'd1,
        SLOT_LINKIDLE = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/tdm_slot_seq.sv
// Step sequencer: owns the run state, the step counter (modulo NUM_CH+3) and
// the per-round live flag. A round is live when some FIFO holds data at its
// spacer step. Assumes any_data is valid in the same cycle as the step.
module tdm_slot_seq
    import tdm_pkg::*;
#(
    parameter int unsigned NUM_CH = 18,
    parameter int unsigned AW     = $clog2(NUM_CH + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          enable,
    input  logic          any_data,
    output logic          run,
    output logic          live,
    output logic [AW-1:0] addr,
    output slot_kind_e    kind
);
    localparam int unsigned SLOTS    = NUM_CH + 3;
    localparam logic [AW-1:0] SPACER_A = AW'(NUM_CH);
    localparam logic [AW-1:0] LAST_A   = AW'(SLOTS - 1);

    logic active_q;
    logic live_q;

    // Arm on link_up with enable, drop as soon as the link is lost
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= link_up & (active_q | enable);
    end

    assign run = active_q & link_up;

    // Step counter: parked at the spacer step while not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      addr <= SPACER_A;
        else if (addr == LAST_A) addr <= '0;
        else                     addr <= addr + 1'b1;
    end

    // Latch the round decision taken at the spacer step
    always_ff @(posedge clk) begin
        if (!rst_n || !run)        live_q <= 1'b0;
        else if (addr == SPACER_A) live_q <= any_data;
    end

    // Current step is live: spacer step decides from present data
    assign live = run & ((addr == SPACER_A) ? any_data : live_q);

    // Classify the current step
    always_comb begin
        if (addr < SPACER_A)       kind = SLOT_CHAN;
        else if (addr == SPACER_A) kind = SLOT_SPACER;
        else                       kind = SLOT_LINKIDLE;
    end

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST_A);
    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && addr == LAST_A) |=> (addr == '0));
    // R10
    park_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (addr == SPACER_A));
endmodule

// File: rtl/tdm_word_patch.sv
// Rewrites the two upper identifier bits of a forwarded word: the error bit
// takes the received parity fault, the parity bit makes the word odd parity.
// Assumes WORD_W >= 8 so both bit positions exist below the top nibble.
module tdm_word_patch #(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] raw,
    input  logic              perr,
    output logic [WORD_W-1:0] patched
);
    localparam int unsigned ERR_BIT = WORD_W - 5;
    localparam int unsigned PAR_BIT = WORD_W - 6;

    logic par_in;

    // Parity of every bit except the one being chosen
    assign par_in  = ^{raw[WORD_W-1:ERR_BIT+1], perr, raw[PAR_BIT-1:0]};
    // Assemble the patched word with the odd-parity fill bit
    assign patched = {raw[WORD_W-1:ERR_BIT+1], perr, ~par_in, raw[PAR_BIT-1:0]};
endmodule

// File: rtl/tdm_mux.sv
// Time-division output multiplexer top. Selects per step among the channel
// FIFO heads, the spacer word and link idle, pops the FIFO it forwards, and
// registers the word and serializer control code. Assumes FIFO head data and
// flags are valid combinationally and a pop takes effect at the clock edge.
module tdm_mux
    import tdm_pkg::*;
#(
    parameter int unsigned NUM_CH = 18,
    parameter int unsigned WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     link_up,
    input  logic                     enable,
    input  logic [NUM_CH-1:0]        fifo_empty,
    input  logic [NUM_CH*WORD_W-1:0] fifo_data,
    input  logic [NUM_CH-1:0]        fifo_perr,
    output logic [NUM_CH-1:0]        fifo_pop,
    output logic [WORD_W-1:0]        tx_data,
    output logic [1:0]               tx_ctrl
);
    localparam int unsigned AW = $clog2(NUM_CH + 3);
    localparam logic [WORD_W-1:0] SPACER_W = {4'hD, {(WORD_W-4){1'b0}}};
    localparam logic [WORD_W-1:0] EMPTY_W  = '0;

    logic              run;
    logic              live;
    logic [AW-1:0]     addr;
    slot_kind_e        kind;
    logic              any_data;
    logic [WORD_W-1:0] sel_data;
    logic              sel_perr;
    logic              sel_empty;
    logic [WORD_W-1:0] patched;
    logic [WORD_W-1:0] nxt_data;
    logic [1:0]        nxt_ctrl;

    assign any_data = |(~fifo_empty);

    tdm_slot_seq #(.NUM_CH(NUM_CH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_up  (link_up),
        .enable   (enable),
        .any_data (any_data),
        .run      (run),
        .live     (live),
        .addr     (addr),
        .kind     (kind)
    );

    // Pick the head of the channel owned by the current step
    always_comb begin
        sel_data  = '0;
        sel_perr  = 1'b0;
        sel_empty = 1'b1;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (addr == AW'(i)) begin
                sel_data  = fifo_data[i*WORD_W +: WORD_W];
                sel_perr  = fifo_perr[i];
                sel_empty = fifo_empty[i];
            end
        end
    end

    tdm_word_patch #(.WORD_W(WORD_W)) u_patch (
        .raw     (sel_data),
        .perr    (sel_perr),
        .patched (patched)
    );

    // One pop strobe per channel, only in its own live step with data
    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_pop
        assign fifo_pop[g] = live && (kind == SLOT_CHAN) &&
                             (addr == AW'(g)) && !fifo_empty[g];
    end

    // Choose the word and control code for the next output cycle
    always_comb begin
        nxt_data = '0;
        nxt_ctrl = CTL_IDLE;
        if (live) begin
            unique case (kind)
                SLOT_SPACER: begin
                    nxt_data = SPACER_W;
                    nxt_ctrl = CTL_DATA;
                end
                SLOT_CHAN: begin
                    nxt_data = sel_empty ? EMPTY_W : patched;
                    nxt_ctrl = CTL_DATA;
                end
                default: begin
                    nxt_data = '0;
                    nxt_ctrl = CTL_IDLE;
                end
            endcase
        end
    end

    // Output register toward the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_ctrl <= CTL_IDLE;
        end else begin
            tx_data <= nxt_data;
            tx_ctrl <= nxt_ctrl;
        end
    end

    // R11
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));
    // R11
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop & fifo_empty) == '0);
    // R10
    link_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (tx_ctrl == CTL_IDLE));
    // R7
    ctrl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ctrl[1] == 1'b0);
    // R6
    odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl == CTL_DATA && tx_data != '0) |-> (^tx_data == 1'b1));
    // R4
    pop_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_pop) |=> (tx_ctrl == CTL_DATA));
endmodule

// File: tb/tdm_mux_bench.sv
// Self-checking bench: models the FIFOs and the round per cycle, mixes
// directed corner cases with seeded random pushes and link events.
module tdm_mux_bench;
    localparam int NCH = 18;
    localparam int W   = 32;
    localparam int DEP = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           link_up = 1'b0;
    logic           enable = 1'b0;
    logic [NCH-1:0] fifo_empty;
    logic [NCH*W-1:0] fifo_data;
    logic [NCH-1:0] fifo_perr;
    logic [NCH-1:0] fifo_pop;
    logic [W-1:0]   tx_data;
    logic [1:0]     tx_ctrl;

    int checks = 0;
    int errors = 0;

    tdm_mux u_tdm_mux (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .enable(enable),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_perr(fifo_perr),
        .fifo_pop(fifo_pop), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
    );

    always #10 clk = ~clk;

    // Bench FIFOs: {perr, word}
    logic [W:0] fmem [NCH][DEP];
    int fcnt [NCH];
    int frd  [NCH];

    // Model state
    bit     m_active, m_live;
    int     m_addr;
    bit     n_active, n_live;
    int     n_addr;
    int     pend_pop;
    logic [W-1:0] exp_data;
    logic [1:0]   exp_ctrl;
    string  exp_tag;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R6: expected patched word from the FIFO word and its error flag
    function automatic logic [W-1:0] patch_fn(input logic [W-1:0] raw, input logic pe);
        logic [W-1:0] o;
        o = raw;
        o[27] = pe;
        o[26] = 1'b0;
        if (^o == 1'b0) o[26] = 1'b1;
        return o;
    endfunction

    task automatic push(input int ch, input logic [W-1:0] d, input logic pe);
        if (fcnt[ch] < DEP) begin
            fmem[ch][(frd[ch] + fcnt[ch]) % DEP] = {pe, d};
            fcnt[ch]++;
        end
    endtask

    task automatic drive_fifos();
        for (int c = 0; c < NCH; c++) begin
            fifo_empty[c] = (fcnt[c] == 0);
            fifo_data[c*W +: W] = fmem[c][frd[c]][W-1:0];
            fifo_perr[c] = fmem[c][frd[c]][W];
        end
    endtask

    // One cycle, called at a falling edge
    task automatic step(input logic lk, input logic en, input int push_pct);
        logic [NCH-1:0] exp_pop;
        bit run, live, any;
        // outputs produced by the last rising edge
        chk(tx_ctrl == exp_ctrl, {exp_tag, " ctrl"}, W'(tx_ctrl), W'(exp_ctrl));
        chk(tx_data == exp_data, {exp_tag, " data"}, tx_data, exp_data);
        // commit last cycle's decisions
        if (pend_pop >= 0) begin
            frd[pend_pop] = (frd[pend_pop] + 1) % DEP;
            fcnt[pend_pop]--;
        end
        m_active = n_active; m_addr = n_addr; m_live = n_live;
        for (int c = 0; c < NCH; c++)
            if (($urandom % 100) < push_pct) push(c, $urandom, 1'($urandom % 4 == 0));
        link_up = lk;
        enable  = en;
        drive_fifos();
        #1;
        run = m_active && lk;
        any = 1'b0;
        for (int c = 0; c < NCH; c++) if (fcnt[c] > 0) any = 1'b1;
        live = run && ((m_addr == NCH) ? any : m_live);
        pend_pop = (live && m_addr < NCH && fcnt[m_addr] > 0) ? m_addr : -1;
        exp_pop = '0;
        if (pend_pop >= 0) exp_pop[pend_pop] = 1'b1;
        // R4 R11: pop strobe in the step itself
        chk(fifo_pop == exp_pop, "R4 R11 pop", W'(fifo_pop), W'(exp_pop));
        if (!run) begin
            exp_data = '0; exp_ctrl = 2'b00;
            exp_tag = (m_active && !lk) ? "R10" : "R8";
        end else if (!live) begin
            exp_data = '0; exp_ctrl = 2'b00; exp_tag = "R9";
        end else if (m_addr == NCH) begin
            exp_data = 32'hD000_0000; exp_ctrl = 2'b01; exp_tag = "R3 R2";
        end else if (m_addr > NCH) begin
            exp_data = '0; exp_ctrl = 2'b00; exp_tag = "R7";
        end else if (pend_pop >= 0) begin
            exp_data = patch_fn(fmem[m_addr][frd[m_addr]][W-1:0], fmem[m_addr][frd[m_addr]][W]);
            exp_ctrl = 2'b01; exp_tag = "R6 R4";
        end else begin
            exp_data = '0; exp_ctrl = 2'b01; exp_tag = "R5";
        end
        n_active = lk && (m_active || en);
        n_addr   = !run ? NCH : ((m_addr == NCH + 2) ? 0 : m_addr + 1);
        n_live   = !run ? 1'b0 : ((m_addr == NCH) ? any : m_live);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NCH; c++) begin
            fcnt[c] = 0; frd[c] = 0;
            for (int k = 0; k < DEP; k++) fmem[c][k] = '0;
        end
        drive_fifos();
        m_active = 0; m_live = 0; m_addr = NCH;
        n_active = 0; n_live = 0; n_addr = NCH;
        pend_pop = -1; exp_data = '0; exp_ctrl = 2'b00; exp_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_ctrl == 2'b00, "R1 ctrl", W'(tx_ctrl), '0);
        chk(tx_data == '0, "R1 data", tx_data, '0);
        chk(fifo_pop == '0, "R1 pop", W'(fifo_pop), '0);
        rst_n = 1'b1;
        // R8: link up but never enabled, with data waiting
        push(3, 32'h3123_4567, 1'b0);
        repeat (8) step(1'b1, 1'b0, 0);
        // R8: enable without link
        repeat (5) step(1'b0, 1'b1, 0);
        // Arm, drain, then suppressed rounds (R9)
        step(1'b1, 1'b1, 0);
        repeat (70) step(1'b1, 1'b0, 0);
        // Corner: first and last channel, parity error set (R6)
        push(0, 32'hFFFF_FFFF, 1'b1);
        push(17, 32'h0000_0000, 1'b1);
        push(17, 32'hA5A5_5A5A, 1'b0);
        repeat (50) step(1'b1, 1'b0, 0);
        // Dense load: every channel busy (R4, R11)
        for (int c = 0; c < NCH; c++) begin
            push(c, $urandom, 1'b0);
            push(c, $urandom, 1'b1);
        end
        repeat (30) step(1'b1, 1'b0, 0);
        // R10: drop the link mid-round with pops pending
        for (int c = 0; c < NCH; c++) push(c, $urandom, 1'b0);
        while (m_addr != 4) step(1'b1, 1'b0, 0);
        repeat (3) step(1'b0, 1'b0, 0);
        repeat (10) step(1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 0);
        repeat (60) step(1'b1, 1'b0, 5);
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int pct;
            pct = (n / 500) % 2 == 0 ? 3 : 0;
            step(($urandom % 400) != 0, ($urandom % 25) == 0, pct);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule